// File: doc/BRIEF.md
# Step-command trigger sequencer

A small programmable sequencer that holds a queue of 8-bit step commands, loaded through a write port, and executes them one after another to coordinate neighbouring logic. Commands stall on a hardware trigger input (edge or level), on a software trigger or on an external timer handshake. They pulse output trigger lines, singly or as a group of eight, pulse interrupt request lines, and drive literal data onto a strobe bus. They also jump, either always or under the control of one of two loop counters, which allows one loop to be nested inside another.

The host loads the queue while `en_i` is low. It picks the first entry with `start_ptr_i`, then raises `en_i` and `start_i`. Each command takes a fetch cycle and at least one execute cycle, followed by `step_dly_i` idle cycles. General-purpose wait timers and a watchdog live outside the block. They see `wait_req_o`/`wait_sel_o` and answer with `wait_done_i`. Dropping `en_i` is what clears them. A debug mode lets a single command run for each request pulse.

Top module: `step_seq`

## Requirements
- R1: A command is 8 bits. Bits [7:4] hold the operation and bits [3:0] the option `o`. Operations: 0 none, 1 wait trigger `o`, 2 wait software trigger, 3 pulse trigger line `o`, 4 pulse trigger line `16+o`, 5 broadcast, 6 interrupt `o`, 7 strobe `{0,o}`, 8 strobe `{1,o}`, 9 strobe `lit_i`, 10 jump, 11 loop jump on counter 0, 12 loop jump on counter 1, 13 wait external timer. Codes 14 and 15 act as none.
- R2: While `en_i` is low, the queue pointer is loaded from `start_ptr_i`. After the last queue entry, execution wraps to entry 0.
- R3: A wait-trigger command completes when input `o` meets its mode. The mode is `trig_mode_i[2o+1:2o]`: 0 rising edge, 1 falling edge, 2 high, 3 low. An edge counts only when it is seen during the wait.
- R4: A wait-external command holds `wait_req_o` high with `wait_sel_o = o` until `wait_done_i` is high.
- R5: Operations 3 and 4 pulse exactly one trigger line: `o` or `16+o`.
- R6: A broadcast pulses trigger lines `8*o[1:0]` through `8*o[1:0]+7` together.
- R7: An interrupt command pulses exactly `irq_o[o]`, and at most one interrupt line is high at any time.
- R8: Strobe commands place their data on `strb_o`, with `strb_vld_o` high for exactly one cycle.
- R9: A jump loads the pointer with `o` (0 if `o` is at or beyond the queue depth).
- R10: A loop jump on a counter that is nonzero decrements the counter and jumps to `o`. On zero it reloads the counter from `loop_lim0_i`/`loop_lim1_i` and falls through. Both counters are reloaded while `en_i` is low.
- R11: After each command completes, `step_dly_i` idle cycles pass before the next fetch. With a delay of 0 a command takes two cycles.
- R12: Trigger and interrupt pulses stay high `pulse_w_i+1` cycles.
- R13: With `en_i` low the sequencer is reset and its outputs are idle. With `en_i` high and `start_i` low it holds its state.
- R14: With `dbg_en_i` high, one command is fetched for each rising edge of `dbg_step_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable; low resets the sequencer |
| start_i | input | 1 | Run; low pauses |
| start_ptr_i | input | AW | First queue entry |
| q_we_i | input | 1 | Queue write strobe |
| q_waddr_i | input | AW | Queue write address |
| q_wdata_i | input | 8 | Queue write command |
| trig_i | input | NTRIG | Hardware trigger inputs |
| trig_mode_i | input | 2*NTRIG | Per-input trigger mode |
| sw_trig_i | input | 1 | Software trigger |
| lit_i | input | LW | Wide literal for strobe |
| loop_lim0_i | input | CW | Loop counter 0 reload value |
| loop_lim1_i | input | CW | Loop counter 1 reload value |
| step_dly_i | input | DW | Idle cycles between commands |
| pulse_w_i | input | PWW | Pulse length minus one |
| dbg_en_i | input | 1 | Single-step mode |
| dbg_step_i | input | 1 | Single-step request |
| wait_req_o | output | 1 | External timer wait request |
| wait_sel_o | output | 4 | Selected timer |
| wait_done_i | input | 1 | External timer finished |
| trig_o | output | NOUT | Output trigger pulses |
| irq_o | output | NIRQ | Interrupt request pulses |
| strb_o | output | LW | Strobe data |
| strb_vld_o | output | 1 | Strobe valid |

## Verification
A table of single commands covers every output-producing operation, separating individual, high-bank, broadcast and interrupt line selection and the three strobe data sources. Trigger waits are tried with a level that is already present under rising mode, which must not fire, with a genuine edge afterwards, and with a low-level mode that completes at once. This separates edge from level detection. A nested two-counter program checks pulse counts that only come out right with both decrement and reload. Pulse periods measured with zero and nonzero step delay, a pulse-length count, pause, start pointer, external wait and single-step runs cover the timing and control paths.

// File: rtl/step_seq_pkg.sv
package step_seq_pkg;
  typedef enum logic [3:0] {
    OP_NOP       = 4'd0,
    OP_WAIT_TRIG = 4'd1,
    OP_WAIT_SW   = 4'd2,
    OP_PULSE_LO  = 4'd3,
    OP_PULSE_HI  = 4'd4,
    OP_BCAST     = 4'd5,
    OP_IRQ       = 4'd6,
    OP_STRB_L0   = 4'd7,
    OP_STRB_L1   = 4'd8,
    OP_STRB_REG  = 4'd9,
    OP_JMP       = 4'd10,
    OP_JMPC0     = 4'd11,
    OP_JMPC1     = 4'd12,
    OP_WAIT_EXT  = 4'd13
  } op_e;

  typedef enum logic [1:0] {
    TM_RISE = 2'd0,
    TM_FALL = 2'd1,
    TM_HIGH = 2'd2,
    TM_LOW  = 2'd3
  } tmode_e;

  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_EXEC  = 2'd1,
    ST_DELAY = 2'd2
  } st_e;
endpackage

// File: rtl/step_seq_queue.sv
module step_seq_queue #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i && (int'(waddr_i) < DEPTH)) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/step_seq_trig.sv
module step_seq_trig
  import step_seq_pkg::*;
#(
  parameter int N = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N-1:0]   trig_i,
  input  logic [2*N-1:0] mode_i,
  output logic [N-1:0]   hit_o
);
  logic [N-1:0] trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= '0;
    else         trig_q <= trig_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_in
    tmode_e mode;
    assign mode = tmode_e'(mode_i[2*g+1:2*g]);
    always_comb begin
      unique case (mode)
        TM_RISE: hit_o[g] = trig_i[g] & ~trig_q[g];
        TM_FALL: hit_o[g] = ~trig_i[g] & trig_q[g];
        TM_HIGH: hit_o[g] = trig_i[g];
        default: hit_o[g] = ~trig_i[g];
      endcase
    end
  end
endmodule

// File: rtl/step_seq_pulse.sv
module step_seq_pulse #(
  parameter int N   = 32,
  parameter int WW  = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [N-1:0]  vec_i,
  input  logic [WW-1:0] width_i,
  output logic [N-1:0]  out_o
);
  logic [N-1:0]  out_q;
  logic [WW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      out_q <= vec_i;
      cnt_q <= width_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end else begin
      out_q <= '0;
    end
  end

  assign out_o = out_q;

  p_pulse_end_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !load_i) |=> (out_q == '0));
endmodule

// File: rtl/step_seq.sv
module step_seq
  import step_seq_pkg::*;
#(
  parameter int QDEPTH = 16,
  parameter int NTRIG  = 16,
  parameter int NOUT   = 32,
  parameter int NIRQ   = 16,
  parameter int CW     = 16,
  parameter int LW     = 16,
  parameter int DW     = 8,
  parameter int PWW    = 4,
  localparam int AW    = $clog2(QDEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             start_i,
  input  logic [AW-1:0]    start_ptr_i,
  input  logic             q_we_i,
  input  logic [AW-1:0]    q_waddr_i,
  input  logic [7:0]       q_wdata_i,
  input  logic [NTRIG-1:0] trig_i,
  input  logic [2*NTRIG-1:0] trig_mode_i,
  input  logic             sw_trig_i,
  input  logic [LW-1:0]    lit_i,
  input  logic [CW-1:0]    loop_lim0_i,
  input  logic [CW-1:0]    loop_lim1_i,
  input  logic [DW-1:0]    step_dly_i,
  input  logic [PWW-1:0]   pulse_w_i,
  input  logic             dbg_en_i,
  input  logic             dbg_step_i,
  output logic             wait_req_o,
  output logic [3:0]       wait_sel_o,
  input  logic             wait_done_i,
  output logic [NOUT-1:0]  trig_o,
  output logic [NIRQ-1:0]  irq_o,
  output logic [LW-1:0]    strb_o,
  output logic             strb_vld_o
);
  st_e          state_q;
  logic [AW-1:0] ptr_q, ptr_nxt, ptr_inc, ptr_tgt;
  logic [7:0]   cmd_q, qdata;
  logic [CW-1:0] cnt0_q, cnt1_q;
  logic [DW-1:0] dly_q;
  logic         tok_q, dbg_q;
  logic [LW-1:0] strb_q;
  logic         vld_q;
  logic [NTRIG-1:0] hit;
  op_e          op;
  logic [3:0]   opt;
  logic         done, fire, run;
  logic         tload, iload;
  logic [NOUT-1:0] tvec;
  logic [NIRQ-1:0] ivec;

  step_seq_queue #(.DEPTH(QDEPTH)) u_queue (
    .clk_i   (clk_i),
    .we_i    (q_we_i),
    .waddr_i (q_waddr_i),
    .wdata_i (q_wdata_i),
    .raddr_i (ptr_q),
    .rdata_o (qdata)
  );

  step_seq_trig #(.N(NTRIG)) u_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig_i),
    .mode_i (trig_mode_i),
    .hit_o  (hit)
  );

  assign op  = op_e'(cmd_q[7:4]);
  assign opt = cmd_q[3:0];
  assign run = en_i & start_i;

  always_comb begin
    unique case (op)
      OP_WAIT_TRIG: done = hit[opt];
      OP_WAIT_SW:   done = sw_trig_i;
      OP_WAIT_EXT:  done = wait_done_i;
      default:      done = 1'b1;
    endcase
  end

  assign fire  = run && (state_q == ST_EXEC) && done;
  assign tload = fire && (op == OP_PULSE_LO || op == OP_PULSE_HI || op == OP_BCAST);
  assign iload = fire && (op == OP_IRQ);

  always_comb begin
    for (int i = 0; i < NOUT; i++) begin
      tvec[i] = (op == OP_PULSE_LO && i == int'(opt)) ||
                (op == OP_PULSE_HI && i == int'(opt) + 16) ||
                (op == OP_BCAST && (i / 8) == int'(opt[1:0]));
    end
    for (int i = 0; i < NIRQ; i++) ivec[i] = (i == int'(opt));
  end

  // pointer arithmetic
  assign ptr_inc = (int'(ptr_q) == QDEPTH - 1) ? '0 : ptr_q + 1'b1;
  assign ptr_tgt = (int'(opt) < QDEPTH) ? AW'(opt) : '0;

  always_comb begin
    unique case (op)
      OP_JMP:   ptr_nxt = ptr_tgt;
      OP_JMPC0: ptr_nxt = (cnt0_q != '0) ? ptr_tgt : ptr_inc;
      OP_JMPC1: ptr_nxt = (cnt1_q != '0) ? ptr_tgt : ptr_inc;
      default:  ptr_nxt = ptr_inc;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FETCH;
      ptr_q   <= '0;
      cmd_q   <= '0;
      cnt0_q  <= '0;
      cnt1_q  <= '0;
      dly_q   <= '0;
      tok_q   <= 1'b0;
      dbg_q   <= 1'b0;
      strb_q  <= '0;
      vld_q   <= 1'b0;
    end else if (!en_i) begin
      state_q <= ST_FETCH;
      ptr_q   <= start_ptr_i;
      cnt0_q  <= loop_lim0_i;
      cnt1_q  <= loop_lim1_i;
      tok_q   <= 1'b0;
      dbg_q   <= dbg_step_i;
      vld_q   <= 1'b0;
    end else begin
      dbg_q <= dbg_step_i;
      vld_q <= 1'b0;
      if (dbg_step_i && !dbg_q) tok_q <= 1'b1;
      if (start_i) begin
        unique case (state_q)
          ST_FETCH: begin
            if (!dbg_en_i || tok_q) begin
              cmd_q   <= qdata;
              state_q <= ST_EXEC;
              tok_q   <= 1'b0;
            end
          end
          ST_EXEC: begin
            if (done) begin
              ptr_q <= ptr_nxt;
              if (op == OP_JMPC0) cnt0_q <= (cnt0_q != '0) ? cnt0_q - 1'b1 : loop_lim0_i;
              if (op == OP_JMPC1) cnt1_q <= (cnt1_q != '0) ? cnt1_q - 1'b1 : loop_lim1_i;
              if (op == OP_STRB_L0 || op == OP_STRB_L1 || op == OP_STRB_REG) begin
                vld_q  <= 1'b1;
                strb_q <= (op == OP_STRB_REG) ? lit_i
                        : LW'({(op == OP_STRB_L1), opt});
              end
              if (step_dly_i == '0) state_q <= ST_FETCH;
              else begin
                state_q <= ST_DELAY;
                dly_q   <= step_dly_i;
              end
            end
          end
          default: begin
            if (dly_q <= 1) state_q <= ST_FETCH;
            else            dly_q   <= dly_q - 1'b1;
          end
        endcase
      end
    end
  end

  step_seq_pulse #(.N(NOUT), .WW(PWW)) u_tpulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (tload),
    .vec_i   (tvec),
    .width_i (pulse_w_i),
    .out_o   (trig_o)
  );

  step_seq_pulse #(.N(NIRQ), .WW(PWW)) u_ipulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (iload),
    .vec_i   (ivec),
    .width_i (pulse_w_i),
    .out_o   (irq_o)
  );

  assign wait_req_o = (state_q == ST_EXEC) && (op == OP_WAIT_EXT);
  assign wait_sel_o = opt;
  assign strb_o     = strb_q;
  assign strb_vld_o = vld_q;

  p_ptr_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(ptr_q) < QDEPTH);
  p_irq_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_o));
  p_strb_once_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_vld_o |=> !strb_vld_o);
  p_wait_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_req_o && !wait_done_i && en_i && start_i) |=> wait_req_o);
  p_stop_idle_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!wait_req_o && !strb_vld_o));
  p_pause_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !start_i) |=> $stable(ptr_q));
endmodule

// File: tb/step_seq_bench.sv
`timescale 1ns/1ps
module step_seq_bench;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, start = 1'b1;
  logic [AW-1:0] start_ptr = '0;
  logic q_we = 1'b0;
  logic [AW-1:0] q_waddr = '0;
  logic [7:0] q_wdata = '0;
  logic [15:0] trig = '0;
  logic [31:0] trig_mode = 32'h0000_C000; // input 5 rising, input 7 low level
  logic sw_trig = 1'b0;
  logic [15:0] lit = 16'hBEEF;
  logic [15:0] lim0 = '0, lim1 = '0;
  logic [7:0] dly = '0;
  logic [3:0] pw = '0;
  logic dbg_en = 1'b0, dbg_step = 1'b0;
  logic wait_req, wait_done = 1'b0;
  logic [3:0] wait_sel;
  logic [31:0] trig_o;
  logic [15:0] irq_o, strb;
  logic strb_vld;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  step_seq u_step_seq (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .start_i(start), .start_ptr_i(start_ptr),
    .q_we_i(q_we), .q_waddr_i(q_waddr), .q_wdata_i(q_wdata),
    .trig_i(trig), .trig_mode_i(trig_mode), .sw_trig_i(sw_trig), .lit_i(lit),
    .loop_lim0_i(lim0), .loop_lim1_i(lim1), .step_dly_i(dly), .pulse_w_i(pw),
    .dbg_en_i(dbg_en), .dbg_step_i(dbg_step),
    .wait_req_o(wait_req), .wait_sel_o(wait_sel), .wait_done_i(wait_done),
    .trig_o(trig_o), .irq_o(irq_o), .strb_o(strb), .strb_vld_o(strb_vld)
  );

  // {cmd, trig_o, irq_o, strb_o, strb_vld_o} one sample after execute
  localparam logic [72:0] VEC [9] = '{
    {8'h33, 32'h0000_0008, 16'h0000, 16'h0000, 1'b0},
    {8'h4F, 32'h8000_0000, 16'h0000, 16'h0000, 1'b0},
    {8'h40, 32'h0001_0000, 16'h0000, 16'h0000, 1'b0},
    {8'h52, 32'h00FF_0000, 16'h0000, 16'h0000, 1'b0},
    {8'h6A, 32'h0000_0000, 16'h0400, 16'h0000, 1'b0},
    {8'h7C, 32'h0000_0000, 16'h0000, 16'h000C, 1'b1},
    {8'h85, 32'h0000_0000, 16'h0000, 16'h0015, 1'b1},
    {8'h90, 32'h0000_0000, 16'h0000, 16'hBEEF, 1'b1},
    {8'hE3, 32'h0000_0000, 16'h0000, 16'h0000, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input int a, input logic [7:0] d);
    q_we = 1'b1; q_waddr = AW'(a); q_wdata = d;
    @(negedge clk);
    q_we = 1'b0;
  endtask

  task automatic stop();
    en = 1'b0;
    @(negedge clk);
  endtask

  // rising edges of two trigger lines over n samples
  task automatic cnt2(input int a, input int b, input int n, output int ca, output int cb);
    logic pa, pb;
    ca = 0; cb = 0; pa = trig_o[a]; pb = trig_o[b];
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (trig_o[a] && !pa) ca++;
      if (trig_o[b] && !pb) cb++;
      pa = trig_o[a]; pb = trig_o[b];
    end
  endtask

  task automatic period(input int a, output int p);
    int t0, t1;
    logic pa;
    t0 = -1; t1 = -1; pa = trig_o[a];
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (trig_o[a] && !pa) begin
        if (t0 < 0) t0 = k;
        else if (t1 < 0) t1 = k;
      end
      pa = trig_o[a];
    end
    p = t1 - t0;
  endtask

  initial begin
    int ca, cb, p, hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk("R13 reset trig", trig_o, 0);
    chk("R13 reset irq", 32'(irq_o), 0);
    chk("R13 reset strobe valid", 32'(strb_vld), 0);
    chk("R13 reset wait", 32'(wait_req), 0);

    // R1 R5 R6 R7 R8: single-command vectors
    for (int i = 0; i < 9; i++) begin
      stop();
      load(0, VEC[i][72:65]);
      load(1, 8'hA1);
      en = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk($sformatf("R1 R5 R6 trig vec%0d", i), trig_o, VEC[i][64:33]);
      chk($sformatf("R1 R7 irq vec%0d", i), 32'(irq_o), 32'(VEC[i][32:17]));
      chk($sformatf("R8 valid vec%0d", i), 32'(strb_vld), 32'(VEC[i][0]));
      if (VEC[i][0]) chk($sformatf("R8 data vec%0d", i), 32'(strb), 32'(VEC[i][16:1]));
    end

    // R3 rising mode ignores a level already present, fires on a fresh edge
    stop();
    trig[5] = 1'b1;
    load(0, 8'h15); load(1, 8'h31); load(2, 8'hA2);
    en = 1'b1;
    cnt2(1, 0, 10, ca, cb);
    chk("R3 rising mode held level", 32'(ca), 0);
    trig[5] = 1'b0; @(negedge clk); trig[5] = 1'b1;
    cnt2(1, 0, 10, ca, cb);
    chk("R3 rising edge fires", 32'(ca), 1);

    // R3 low-level mode completes at once
    stop();
    load(0, 8'h17); load(1, 8'h34); load(2, 8'hA2);
    en = 1'b1;
    cnt2(4, 0, 8, ca, cb);
    chk("R3 low level", 32'(ca), 1);

    // R1 software trigger wait
    stop();
    load(0, 8'h20); load(1, 8'h33); load(2, 8'hA2);
    en = 1'b1;
    cnt2(3, 0, 8, ca, cb);
    chk("R1 sw wait stalls", 32'(ca), 0);
    sw_trig = 1'b1; @(negedge clk); sw_trig = 1'b0;
    cnt2(3, 0, 8, ca, cb);
    chk("R1 sw wait releases", 32'(ca), 1);

    // R4 external timer handshake
    stop();
    load(0, 8'hD3); load(1, 8'h32); load(2, 8'hA2);
    en = 1'b1;
    cnt2(2, 0, 6, ca, cb);
    chk("R4 wait request", 32'(wait_req), 1);
    chk("R4 wait select", 32'(wait_sel), 3);
    chk("R4 no pulse while waiting", 32'(ca), 0);
    wait_done = 1'b1; @(negedge clk); wait_done = 1'b0;
    cnt2(2, 0, 8, ca, cb);
    chk("R4 pulse after done", 32'(ca), 1);
    chk("R4 request dropped", 32'(wait_req), 0);

    // R10 nested loops: inner 2 passes, outer 3 passes
    stop();
    lim0 = 16'd1; lim1 = 16'd2;
    load(0, 8'h30); load(1, 8'hB0); load(2, 8'h31); load(3, 8'hC0); load(4, 8'hA4);
    en = 1'b1;
    cnt2(0, 1, 120, ca, cb);
    chk("R10 inner pulses", 32'(ca), 6);
    chk("R10 outer pulses", 32'(cb), 3);

    // R9 R11 loop period without and with step delay
    stop();
    load(0, 8'h30); load(1, 8'hA0);
    en = 1'b1;
    period(0, p);
    chk("R9 R11 period delay 0", 32'(p), 4);
    stop();
    dly = 8'd3;
    en = 1'b1;
    period(0, p);
    chk("R11 period delay 3", 32'(p), 10);
    dly = 8'd0;

    // R13 pause holds, resume runs
    stop();
    start = 1'b0;
    en = 1'b1;
    cnt2(0, 1, 20, ca, cb);
    chk("R13 paused", 32'(ca), 0);
    start = 1'b1;
    cnt2(0, 1, 20, ca, cb);
    chk("R13 resumed", 32'(ca > 0), 1);

    // R12 pulse length
    stop();
    pw = 4'd5;
    load(0, 8'h30); load(1, 8'hA1);
    en = 1'b1;
    hi = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (trig_o[0]) hi++;
    end
    chk("R12 pulse length", 32'(hi), 6);
    pw = 4'd0;

    // R2 start pointer
    stop();
    start_ptr = 4'd2;
    load(0, 8'h30); load(2, 8'h35); load(3, 8'hA3);
    stop();
    en = 1'b1;
    cnt2(5, 0, 10, ca, cb);
    chk("R2 start entry runs", 32'(ca), 1);
    chk("R2 entry 0 skipped", 32'(cb), 0);
    start_ptr = 4'd0;

    // R2 wrap after last entry
    stop();
    load(15, 8'h37); load(0, 8'h36); load(1, 8'hA1);
    start_ptr = 4'd15;
    stop();
    en = 1'b1;
    cnt2(7, 6, 12, ca, cb);
    chk("R2 wrap last", 32'(ca), 1);
    chk("R2 wrap first", 32'(cb), 1);
    start_ptr = 4'd0;

    // R14 single step
    stop();
    dbg_en = 1'b1;
    load(0, 8'h30); load(1, 8'h31); load(2, 8'hA2);
    en = 1'b1;
    cnt2(0, 1, 10, ca, cb);
    chk("R14 no step no run", 32'(ca + cb), 0);
    dbg_step = 1'b1; @(negedge clk); dbg_step = 1'b0;
    cnt2(0, 1, 10, ca, cb);
    chk("R14 first step", 32'(ca), 1);
    chk("R14 only one", 32'(cb), 0);
    dbg_step = 1'b1; @(negedge clk); dbg_step = 1'b0;
    cnt2(0, 1, 10, ca, cb);
    chk("R14 second step", 32'(cb), 1);
    dbg_en = 1'b0;

    // R13 disable clears outputs
    stop();
    @(negedge clk);
    chk("R13 disabled idle", 32'(wait_req | strb_vld), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule